// File: doc/BRIEF.md
# 16-Point In-Place FFT Sequencer

This block drives the memory and arithmetic pipeline of a 16-point radix-4 decimation-in-time transform that is kept in place in a dual-port RAM. It does not touch sample data. It produces addresses, enables and a twiddle exponent. The RAM, the radix-4 butterfly and the CORDIC rotator sit outside. After `start`, the block writes sixteen incoming samples to digit-reversed locations. It then runs two butterfly stages and streams the finished spectrum out in natural order.

Each stage reads one sample per cycle, so one butterfly takes four cycles. Every read carries the exponent e of its twiddle factor W16^e, taken from the read counter rather than from a table. The rotator rotates the sample by e/16 of a turn, and the butterfly groups samples in fours using `grp_start`. The results return through the RAM's second port. Each write-back address is the read address delayed by the parameter `LAT`, which is the combined latency of the rotator and the butterfly. This lets the reads of one butterfly overlap the writes of earlier ones. After the last read of a stage, the block waits `LAT` cycles before the next stage begins reading, so no stale value is read.

Top module: `fft16_seq`

## Requirements
- R1: After reset the block is idle: `rd_en`, `wr_en`, `done` and `unload` are 0.
- R2: A `start` seen while idle opens a load phase in the next cycle. In that phase each cycle with `in_valid` high writes input sample n (n = 0..15, counted over accepted samples) with `wr_en`=1, `wr_sel`=0 and `wr_addr` = {n[1:0], n[3:2]}, which swaps the two base-4 digits. A cycle with `in_valid` low writes nothing, and no read happens during loading.
- R3: Stage 0 starts in the cycle after the sixteenth sample is accepted. For 16 cycles c = 0..15 it reads `rd_addr` = c with `tw_exp` = 0. `grp_start` is high when c mod 4 = 0.
- R4: Stage 1 starts `16+LAT` cycles after stage 0 starts. For 16 cycles c = 4k + j it reads `rd_addr` = k + 4j with `tw_exp` = j*k. `grp_start` is high when j = 0, and the first sample of every butterfly carries `tw_exp` = 0.
- R5: Each stage read is written back to the same address exactly `LAT` cycles later, with `wr_en`=1 and `wr_sel`=1. No other write-back occurs.
- R6: `done` is high for exactly one cycle, the cycle right after the last write-back of stage 1.
- R7: Starting in the `done` cycle, `unload` and `rd_en` stay high for 16 cycles, with `rd_addr` counting 0..15 and no write. After that the block is idle.
- R8: `start` has no effect while the block is not idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transform (taken only when idle) |
| in_valid | input | 1 | An input sample is present during loading |
| rd_en | output | 1 | RAM read enable |
| rd_addr | output | 4 | RAM read address |
| tw_exp | output | 4 | Twiddle exponent e of W16^e for the sample being read |
| grp_start | output | 1 | This read is the first of a butterfly |
| wr_en | output | 1 | RAM write enable |
| wr_addr | output | 4 | RAM write address |
| wr_sel | output | 1 | Write data source: 0 = input sample, 1 = butterfly result |
| done | output | 1 | One-cycle pulse when the transform is complete |
| unload | output | 1 | Reads are output readout in natural order |

## Verification
Load writes show on the ports in the same cycle as `in_valid`. Stage 0 reads start one cycle after the sixteenth accepted sample, and stage 1 reads start `16+LAT` cycles after stage 0 reads start. Each write-back comes `LAT` cycles after its read, and `done` with readout follows one cycle after the final write-back. The bench follows this schedule one clock at a time. It drives inputs and samples outputs one time step after each falling edge, comparing every cycle of every phase with a schedule computed from these offsets. It issues stray `start` pulses mid-run and leaves idle gaps in `in_valid`, then checks that the schedule does not shift.

// File: rtl/fft16_seq.sv
module fft16_seq #(
  parameter int LAT = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       in_valid,
  output logic       rd_en,
  output logic [3:0] rd_addr,
  output logic [3:0] tw_exp,
  output logic       grp_start,
  output logic       wr_en,
  output logic [3:0] wr_addr,
  output logic       wr_sel,
  output logic       done,
  output logic       unload
);
  localparam int NPT      = 16;
  localparam int AW       = 4;
  localparam int STEP_LEN = NPT + LAT;
  localparam int CW       = $clog2(STEP_LEN + 1);

  typedef enum logic [2:0] {IDLE, LOAD, ST0, ST1, FIN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [LAT-1:0] pv;
  logic [AW-1:0]  pa [LAT];

  wire [AW-1:0] c4        = cnt[AW-1:0];
  wire [AW-1:0] swp       = {c4[1:0], c4[3:2]};
  wire          last_step = (cnt == CW'(STEP_LEN - 1));
  wire          issue     = (st == ST0 || st == ST1) && (cnt < CW'(NPT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= IDLE;
      cnt <= '0;
    end else begin
      case (st)
        IDLE: if (start) begin st <= LOAD; cnt <= '0; end
        LOAD: if (in_valid) begin
          if (c4 == 4'd15) begin st <= ST0; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        ST0: if (last_step) begin st <= ST1; cnt <= '0; end
             else cnt <= cnt + 1'b1;
        ST1: if (last_step) begin st <= FIN; cnt <= '0; end
             else cnt <= cnt + 1'b1;
        FIN: if (c4 == 4'd15) begin st <= IDLE; cnt <= '0; end
             else cnt <= cnt + 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv <= '0;
    else begin
      pv[0] <= issue;
      for (int i = 1; i < LAT; i++) pv[i] <= pv[i-1];
    end
  end

  always_ff @(posedge clk) begin
    pa[0] <= rd_addr;
    for (int i = 1; i < LAT; i++) pa[i] <= pa[i-1];
  end

  assign rd_en     = issue || (st == FIN);
  assign rd_addr   = (st == ST1) ? swp : c4;
  assign tw_exp    = (st == ST1 && issue) ? ({2'b00, c4[1:0]} * {2'b00, c4[3:2]}) : 4'd0;
  assign grp_start = issue && (c4[1:0] == 2'd0);
  assign wr_sel    = pv[LAT-1];
  assign wr_en     = (st == LOAD && in_valid) || pv[LAT-1];
  assign wr_addr   = pv[LAT-1] ? pa[LAT-1] : swp;
  assign done      = (st == FIN) && (c4 == 4'd0);
  assign unload    = (st == FIN);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                   // R6
  AST_LOAD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |-> !rd_en);                                    // R2
  AST_FIRST_UNROTATED: assert property (@(posedge clk) disable iff (!rst_n)
    grp_start |-> (tw_exp == 4'd0));                                   // R4
  AST_UNLOAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    unload |-> !wr_en);                                                // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st != IDLE && start) |=> (st != LOAD || $past(st) == LOAD));      // R8
endmodule

// File: tb/fft16_seq_bench.sv
module fft16_seq_bench;
  localparam int PERIOD = 10;
  localparam int LAT    = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0;
  logic rd_en, grp_start, wr_en, wr_sel, done, unload;
  logic [3:0] rd_addr, tw_exp, wr_addr;
  int checks = 0, errors = 0;
  bit finished = 0;

  fft16_seq #(.LAT(LAT)) u_fft16_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .rd_en(rd_en), .rd_addr(rd_addr), .tw_exp(tw_exp), .grp_start(grp_start),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_sel(wr_sel), .done(done), .unload(unload));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic int swap4(input int n);
    return (n % 4) * 4 + n / 4;
  endfunction

  task automatic check_reset();
    #1;
    chk("R1 rd_en", rd_en, 0);
    chk("R1 wr_en", wr_en, 0);
    chk("R1 done", done, 0);
    chk("R1 unload", unload, 0);
  endtask

  task automatic load_frame(input int gap_every);
    step(); start = 1'b1; in_valid = 1'b1; #1;
    chk("R2 no write while idle", wr_en, 0);
    for (int n = 0; n < 16; n++) begin
      if (gap_every > 0 && n % gap_every == 1) begin
        step(); start = 1'b0; in_valid = 1'b0; #1;
        chk("R2 gap no write", wr_en, 0);
        chk("R2 gap no read", rd_en, 0);
      end
      step(); start = (n == 7); in_valid = 1'b1; #1;
      chk("R2 wr_en", wr_en, 1);
      chk("R2 wr_sel", wr_sel, 0);
      chk("R2 wr_addr", wr_addr, swap4(n));
      chk("R2 no read", rd_en, 0);
    end
  endtask

  task automatic run_stage(input int s);
    for (int c = 0; c < 16 + LAT; c++) begin
      step(); start = (c == 5); in_valid = 1'b1; #1;
      chk(s == 0 ? "R3 rd_en" : "R4 rd_en", rd_en, c < 16);
      if (c < 16) begin
        if (s == 0) begin
          chk("R3 rd_addr", rd_addr, c);
          chk("R3 tw_exp", tw_exp, 0);
          chk("R3 grp_start", grp_start, c % 4 == 0);
        end else begin
          chk("R4 rd_addr", rd_addr, swap4(c));
          chk("R4 tw_exp", tw_exp, (c % 4) * (c / 4));
          chk("R4 grp_start", grp_start, c % 4 == 0);
        end
      end
      chk("R5 wr_en", wr_en, c >= LAT);
      if (c >= LAT) begin
        chk("R5 wr_sel", wr_sel, 1);
        chk("R5 wr_addr", wr_addr, s == 0 ? c - LAT : swap4(c - LAT));
      end
      chk("R6 no early done", done, 0);
    end
  endtask

  task automatic unload_phase();
    for (int c = 0; c < 16; c++) begin
      step(); start = (c == 4); in_valid = 1'b0; #1;
      chk("R6 done", done, c == 0);
      chk("R7 unload", unload, 1);
      chk("R7 rd_en", rd_en, 1);
      chk("R7 rd_addr", rd_addr, c);
      chk("R7 no write", wr_en, 0);
    end
    step(); start = 1'b0; #1;
    chk("R7 idle rd_en", rd_en, 0);
    chk("R7 idle unload", unload, 0);
    chk("R8 no restart load", wr_en, 0);
  endtask

  task automatic idle_start_ignored_without_start();
    step(); in_valid = 1'b1; #1;
    chk("R8 idle ignores in_valid", wr_en, 0);
    step(); in_valid = 1'b0; #1;
    chk("R1 still idle", rd_en, 0);
  endtask

  task automatic transform(input int gap_every);
    load_frame(gap_every);
    run_stage(0);
    run_stage(1);
    unload_phase();
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
  end

  initial begin
    check_reset();
    #(PERIOD * 2 + 3);
    rst_n = 1'b1;
    check_reset();
    transform(0);
    idle_start_ignored_without_start();
    transform(3);
    transform(1);
    report();
  end
endmodule